// File: doc/BRIEF.md
# Burst Request Legality Monitor

A passive observer placed beside a slave port of an AXI-style interconnect. It watches the write-address, read-address and write-data channels and reports every request that a simple memory adapter downstream could not serve. That adapter handles bursts only on bus-aligned addresses, only at full bus width, only with the legal wrap lengths, only without crossing a 4 KB page, and only with a write-data stream whose last-beat marker matches the announced length exactly. The monitor never drives a ready or valid signal and leaves the traffic untouched.

Each rule owns one sticky bit in an error vector. Any violation also raises a one-cycle pulse and records the ID of the request at fault. The flags stay set until a synchronous clear is given. Write bursts are followed one at a time: a beat counter is loaded by the write-address handshake and is compared with the last-beat marker on every accepted data beat.

Top module: `axi_burst_lint`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released, `err_flags` is all zero, `err_pulse` is 0 and `err_id` is 0.
- R2: A read or write address handshake with burst code 2'b11 sets flag bit 0. The burst codes are 2'b00 fixed, 2'b01 incrementing, 2'b10 wrapping and 2'b11 reserved.
- R3: A wrapping request whose length field is not 1, 3, 7 or 15 (that is, not 2, 4, 8 or 16 beats) sets flag bit 1. A wrapping request with one of those lengths does not set it.
- R4: An incrementing request whose last byte, at start + (len+1)·2^size − 1, lies in a different 4 KB page from its start sets flag bit 2. A burst that ends exactly on the page end does not set it, and fixed and wrapping bursts are never checked against this rule.
- R5: A request whose address has any of its low log2(DATA_W/8) bits set sets flag bit 3.
- R6: A request whose size field differs from log2(DATA_W/8) (2 for a 32-bit bus) sets flag bit 4.
- R7: An accepted write beat that carries the last marker while the beat count is still below the announced length sets flag bit 5 and ends the tracked burst. Later beats are not checked until the next write address.
- R8: An accepted write beat at beat index len that carries no last marker sets flag bit 6 and ends the tracked burst.
- R9: A write-address handshake while a tracked write burst is still open, and the burst does not finish in that same cycle, sets flag bit 7. The new burst then replaces the old one.
- R10: Rules are evaluated only on a handshake (valid and ready both 1). A request held valid without ready has no effect on any output.
- R11: `err_pulse` is 1 for exactly the cycle after the clock edge that samples a violation, and `err_id` is loaded at the same edge. For the ID the write address (bits 0 to 4 and 7) has priority over the write data (bits 5 and 6, which report the tracked write ID), and the write data has priority over the read address. With no violation, `err_id` holds its value.
- R12: Flags are sticky. A `clr` pulse empties them at the next edge, but a violation sampled at that same edge is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sticky flags |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write start address |
| aw_len | input | 4 | Write length, beats minus one |
| aw_size | input | 3 | Write log2 bytes per beat |
| aw_burst | input | 2 | Write burst code |
| aw_id | input | ID_W | Write transaction ID |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | input | ADDR_W | Read start address |
| ar_len | input | 4 | Read length, beats minus one |
| ar_size | input | 3 | Read log2 bytes per beat |
| ar_burst | input | 2 | Read burst code |
| ar_id | input | ID_W | Read transaction ID |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Write data last-beat marker |
| err_flags | output | 8 | Sticky per-rule flags, bits as in R2 to R9 |
| err_pulse | output | 1 | One-cycle pulse for a new violation |
| err_id | output | ID_W | ID of the most recent offending request |

## Verification
Every result is registered once. A violation sampled at a clock edge therefore shows up in `err_flags`, `err_pulse` and `err_id` right after that same edge, and is due one cycle after the stimulus was applied. The bench changes its inputs 1 ns after a rising edge and waits for the next rising edge. It then compares all three outputs 1 ns later with a model that first evaluates the rules and the write-beat state on the old state and only then applies the new write address. The random mix and the directed cases share that single-cycle step, so every check samples the cycle in which its expected value becomes valid.

// File: rtl/axi_lint_pkg.sv
package axi_lint_pkg;

  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;

  localparam int RULE_N    = 8;
  localparam int ADDR_RULES = 5;
  localparam int E_BTYPE   = 0;
  localparam int E_WRAPLEN = 1;
  localparam int E_PAGE    = 2;
  localparam int E_ALIGN   = 3;
  localparam int E_SIZE    = 4;
  localparam int E_EARLY   = 5;
  localparam int E_NOLAST  = 6;
  localparam int E_OVERLAP = 7;

  // Wrap bursts must span 2, 4, 8 or 16 beats.
  function automatic logic wrap_len_ok(input logic [3:0] len);
    return (len == 4'd1) || (len == 4'd3) || (len == 4'd7) || (len == 4'd15);
  endfunction

endpackage

// File: rtl/axi_req_rules.sv
module axi_req_rules
  import axi_lint_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  hs,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [3:0]            len,
  input  logic [2:0]            size,
  input  burst_e                burst,
  output logic [ADDR_RULES-1:0] viol
);
  localparam int BYTES = DATA_W / 8;
  localparam int LOG_B = $clog2(BYTES);
  localparam int PAGE_LSB = 12;

  function automatic logic leaves_page(input logic [ADDR_W-1:0] a,
                                       input logic [3:0] l,
                                       input logic [2:0] s);
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] last_byte;
    span      = ADDR_W'({1'b0, l} + 5'd1) << s;
    last_byte = a + span - ADDR_W'(1);
    return last_byte[ADDR_W-1:PAGE_LSB] != a[ADDR_W-1:PAGE_LSB];
  endfunction

  logic misalign;

  generate
    if (LOG_B == 0) begin : g_byte_bus
      assign misalign = 1'b0;
    end else begin : g_wide_bus
      assign misalign = |addr[LOG_B-1:0];
    end
  endgenerate

  always_comb begin
    viol            = '0;
    viol[E_BTYPE]   = hs && (burst == BT_RSVD);
    viol[E_WRAPLEN] = hs && (burst == BT_WRAP) && !wrap_len_ok(len);
    viol[E_PAGE]    = hs && (burst == BT_INCR) && leaves_page(addr, len, size);
    viol[E_ALIGN]   = hs && misalign;
    viol[E_SIZE]    = hs && (size != 3'(LOG_B));
  end

endmodule

// File: rtl/axi_wbeat_track.sv
module axi_wbeat_track #(
  parameter int ID_W  = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aw_hs,
  input  logic [LEN_W-1:0] aw_len,
  input  logic [ID_W-1:0]  aw_id,
  input  logic             w_hs,
  input  logic             w_last,
  output logic             early_last,
  output logic             miss_last,
  output logic             overlap,
  output logic [ID_W-1:0]  cur_id
);
  logic             busy;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic             final_beat;
  logic             end_now;

  assign final_beat = (cnt == len_q);
  assign end_now    = busy && w_hs && (w_last || final_beat);
  assign early_last = busy && w_hs && w_last && !final_beat;
  assign miss_last  = busy && w_hs && !w_last && final_beat;
  assign overlap    = aw_hs && busy && !end_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      cur_id <= '0;
    end else if (aw_hs) begin
      busy   <= 1'b1;
      cnt    <= '0;
      len_q  <= aw_len;
      cur_id <= aw_id;
    end else if (end_now) begin
      busy <= 1'b0;
    end else if (busy && w_hs) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= len_q));

  // R7
  last_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && w_hs && w_last && !aw_hs) |=> !busy);

endmodule

// File: rtl/axi_burst_lint.sv
module axi_burst_lint
  import axi_lint_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [3:0]        aw_len,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [3:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic              w_last,
  output logic [7:0]        err_flags,
  output logic              err_pulse,
  output logic [ID_W-1:0]   err_id
);
  localparam int NCH = 2;  // channel 0 = write address, 1 = read address

  logic aw_hs, ar_hs, w_hs;
  assign aw_hs = aw_valid && aw_ready;
  assign ar_hs = ar_valid && ar_ready;
  assign w_hs  = w_valid && w_ready;

  logic                  ch_hs    [NCH];
  logic [ADDR_W-1:0]     ch_addr  [NCH];
  logic [3:0]            ch_len   [NCH];
  logic [2:0]            ch_size  [NCH];
  burst_e                ch_burst [NCH];
  logic [ADDR_RULES-1:0] ch_viol  [NCH];

  assign ch_hs[0] = aw_hs;    assign ch_hs[1] = ar_hs;
  assign ch_addr[0] = aw_addr;  assign ch_addr[1] = ar_addr;
  assign ch_len[0] = aw_len;   assign ch_len[1] = ar_len;
  assign ch_size[0] = aw_size;  assign ch_size[1] = ar_size;
  assign ch_burst[0] = burst_e'(aw_burst);
  assign ch_burst[1] = burst_e'(ar_burst);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      axi_req_rules #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rules (
        .hs   (ch_hs[c]),
        .addr (ch_addr[c]),
        .len  (ch_len[c]),
        .size (ch_size[c]),
        .burst(ch_burst[c]),
        .viol (ch_viol[c])
      );
    end
  endgenerate

  logic            early_last, miss_last, overlap;
  logic [ID_W-1:0] trk_id;

  axi_wbeat_track #(.ID_W(ID_W), .LEN_W(4)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .aw_hs     (aw_hs),
    .aw_len    (aw_len),
    .aw_id     (aw_id),
    .w_hs      (w_hs),
    .w_last    (w_last),
    .early_last(early_last),
    .miss_last (miss_last),
    .overlap   (overlap),
    .cur_id    (trk_id)
  );

  logic [RULE_N-1:0] new_viol;
  logic              any_new;
  logic              aw_fault, w_fault, ar_fault;
  logic [ID_W-1:0]   id_next;

  always_comb begin
    new_viol                   = '0;
    new_viol[ADDR_RULES-1:0]   = ch_viol[0] | ch_viol[1];
    new_viol[E_EARLY]          = early_last;
    new_viol[E_NOLAST]         = miss_last;
    new_viol[E_OVERLAP]        = overlap;
  end

  assign any_new  = |new_viol;
  assign aw_fault = (|ch_viol[0]) || overlap;
  assign w_fault  = early_last || miss_last;
  assign ar_fault = |ch_viol[1];

  always_comb begin
    if (aw_fault)      id_next = aw_id;
    else if (w_fault)  id_next = trk_id;
    else if (ar_fault) id_next = ar_id;
    else               id_next = err_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_pulse <= 1'b0;
      err_id    <= '0;
    end else begin
      err_flags <= (clr ? '0 : err_flags) | new_viol;
      err_pulse <= any_new;
      err_id    <= id_next;
    end
  end

  // R11
  pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_flags != '0));

  // R10
  pulse_needs_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(aw_hs || ar_hs || w_hs));

  // R12
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R12
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_new) |=> (err_flags == '0));

  // R11
  id_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_new |=> $stable(err_id));

endmodule

// File: tb/tb_axi_burst_lint.sv
`timescale 1ns/1ps
module tb_axi_burst_lint;
  localparam int ID_W = 4;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic aw_valid = 0, aw_ready = 0, ar_valid = 0, ar_ready = 0;
  logic w_valid = 0, w_ready = 0, w_last = 0;
  logic [ADDR_W-1:0] aw_addr = 0, ar_addr = 0;
  logic [3:0] aw_len = 0, ar_len = 0;
  logic [2:0] aw_size = 2, ar_size = 2;
  logic [1:0] aw_burst = 1, ar_burst = 1;
  logic [ID_W-1:0] aw_id = 0, ar_id = 0;
  logic [7:0] err_flags;
  logic err_pulse;
  logic [ID_W-1:0] err_id;

  always #5 clk = ~clk;

  axi_burst_lint #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_burst(aw_burst), .aw_id(aw_id),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .ar_size(ar_size), .ar_burst(ar_burst), .ar_id(ar_id),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .err_flags(err_flags), .err_pulse(err_pulse), .err_id(err_id)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_flags = 0;
  logic exp_pulse = 0;
  logic [ID_W-1:0] exp_id = 0;
  bit busy_b = 0;
  int cnt_b = 0, len_b = 0;
  logic [ID_W-1:0] id_b = 0;
  bit done = 0;

  // Bench restatement of the address rules, 32-bit bus (4 bytes per beat).
  function automatic logic [4:0] exp_rules(input logic [31:0] a, input int l,
                                           input int s, input int b);
    logic [4:0] r;
    int beats;
    beats = l + 1;
    r = 0;
    r[0] = (b == 3);
    r[1] = (b == 2) && !(beats == 2 || beats == 4 || beats == 8 || beats == 16);
    r[2] = (b == 1) && ((int'(a % 4096) + beats * (1 << s)) > 4096);
    r[3] = (a % 4) != 0;
    r[4] = (s != 2);
    return r;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (err_flags !== exp_flags || err_pulse !== exp_pulse || err_id !== exp_id) begin
      errors++;
      $display("FAIL %s: flags=%b pulse=%b id=%0d expected flags=%b pulse=%b id=%0d",
               tag, err_flags, err_pulse, err_id, exp_flags, exp_pulse, exp_id);
    end
  endtask

  // Inputs are already driven; model the edge, wait for it, compare, release.
  task automatic apply(input string tag);
    logic [4:0] vaw, var_;
    logic early, miss, ov, w_end;
    logic [7:0] nv;
    bit whs;
    vaw  = (aw_valid && aw_ready) ? exp_rules(aw_addr, aw_len, aw_size, aw_burst) : 5'b0;
    var_ = (ar_valid && ar_ready) ? exp_rules(ar_addr, ar_len, ar_size, ar_burst) : 5'b0;
    whs  = w_valid && w_ready;
    early = busy_b && whs && w_last && (cnt_b != len_b);
    miss  = busy_b && whs && !w_last && (cnt_b == len_b);
    w_end = busy_b && whs && (w_last || cnt_b == len_b);
    ov    = aw_valid && aw_ready && busy_b && !w_end;
    nv = {ov, miss, early, vaw | var_};
    if (|vaw || ov) exp_id = aw_id;
    else if (early || miss) exp_id = id_b;
    else if (|var_) exp_id = ar_id;
    exp_flags = (clr ? 8'h00 : exp_flags) | nv;
    exp_pulse = |nv;
    if (aw_valid && aw_ready) begin
      busy_b = 1; cnt_b = 0; len_b = aw_len; id_b = aw_id;
    end else if (w_end) busy_b = 0;
    else if (busy_b && whs) cnt_b++;
    @(posedge clk); #1;
    check(tag);
    aw_valid = 0; aw_ready = 0; ar_valid = 0; ar_ready = 0;
    w_valid = 0; w_ready = 0; w_last = 0; clr = 0;
  endtask

  task automatic set_ar(input logic [31:0] a, input int l, input int s, input int b,
                        input int id, input bit rdy);
    ar_valid = 1; ar_ready = rdy; ar_addr = a; ar_len = 4'(l);
    ar_size = 3'(s); ar_burst = 2'(b); ar_id = ID_W'(id);
  endtask

  task automatic set_aw(input logic [31:0] a, input int l, input int s, input int b,
                        input int id);
    aw_valid = 1; aw_ready = 1; aw_addr = a; aw_len = 4'(l);
    aw_size = 3'(s); aw_burst = 2'(b); aw_id = ID_W'(id);
  endtask

  task automatic beat(input bit last);
    w_valid = 1; w_ready = 1; w_last = last;
  endtask

  task automatic clear_all(input string tag);
    clr = 1; apply(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    #3; check("R1 during reset");
    #20; rst_n = 1;
    @(posedge clk); #1;
    check("R1 after reset");

    set_ar(32'h100, 3, 2, 3, 5, 1); apply("R2 reserved burst");
    set_ar(32'h200, 2, 2, 2, 6, 1); apply("R3 wrap 3 beats");
    set_ar(32'h200, 3, 2, 2, 7, 1); apply("R3 wrap 4 beats legal");
    clear_all("R12 clear");
    set_ar(32'hFF0, 3, 2, 1, 1, 1); apply("R4 ends on page end");
    set_ar(32'hFF4, 3, 2, 1, 2, 1); apply("R4 crosses page");
    set_ar(32'hFFC, 15, 2, 0, 3, 1); apply("R4 fixed not checked");
    set_ar(32'h102, 0, 2, 1, 4, 1); apply("R5 misaligned");
    set_ar(32'h104, 0, 1, 1, 8, 1); apply("R6 narrow size");
    clear_all("R12 clear");
    set_ar(32'h1003, 0, 1, 3, 9, 0); apply("R10 no ready ignored");
    set_aw(32'h400, 3, 2, 1, 10); apply("R7 aw");
    beat(0); apply("R7 beat0");
    beat(1); apply("R7 early last");
    beat(0); apply("R7 beat after end ignored");
    set_aw(32'h500, 1, 2, 1, 11); apply("R8 aw");
    beat(0); apply("R8 beat0");
    beat(0); apply("R8 missing last");
    set_aw(32'h600, 2, 2, 1, 12); apply("R9 aw");
    beat(0); apply("R9 beat0");
    set_aw(32'h700, 0, 2, 1, 13); apply("R9 overlap");
    beat(1); apply("R9 new burst closes");
    set_aw(32'h800, 0, 2, 1, 14); beat(1); apply("R9 aw and beat");
    beat(1); apply("R9 single beat");
    set_aw(32'h801, 0, 2, 1, 2); set_ar(32'h3, 0, 2, 1, 9, 1); apply("R11 aw over ar");
    set_aw(32'h900, 0, 2, 1, 4); apply("R11 aw");
    beat(0); set_ar(32'h7, 0, 2, 1, 6, 1); apply("R11 w over ar");
    set_ar(32'h0, 0, 2, 1, 1, 1); apply("R11 id holds");
    clr = 1; set_ar(32'h0, 0, 2, 3, 15, 1); apply("R12 clear with new violation");

    for (int i = 0; i < 600; i++) begin
      int kind, l, s, b;
      logic [31:0] a;
      kind = int'($urandom % 8);
      l = int'($urandom % 16);
      s = ($urandom % 5 == 0) ? int'($urandom % 8) : 2;
      b = ($urandom % 6 == 0) ? 3 : int'($urandom % 3);
      a = $urandom;
      if ($urandom % 4 != 0) a[1:0] = 2'b00;
      if ($urandom % 3 == 0) a[11:6] = 6'h3F;
      if (busy_b && kind < 5) begin
        beat(($urandom % 6 == 0) ? (cnt_b != len_b) : (cnt_b == len_b));
        apply("R7 R8 random beat");
      end else if (kind < 3) begin
        set_aw(a, l, s, b, int'($urandom % 16));
        apply("R9 random aw");
      end else if (kind == 7) begin
        clear_all("R12 random clear");
      end else begin
        set_ar(a, l, s, b, int'($urandom % 16), ($urandom % 8) != 0);
        apply("R10 random ar");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule